// File: doc/BRIEF.md
# Crosstalk-Aware Variable-Cycle Bus Transmitter

This block drives a parallel bus that runs on a fast clock. When the sender offers a new word, the block compares it, line by line, with the word now on the wires. For each line it grades the coupling that the change would put on that line from its two neighbours. The worst grade on any line selects how many fast cycles the new word is held on the wires before the receiver is told to take it.

Quiet or uniform changes cost one short cycle. Opposing transitions on adjacent wires cost more. The bus therefore runs close to its best-case rate and slows only for the patterns that need it, with no extra wires and no coding. The input side is a valid/ready handshake. On the far side, a one-cycle strobe marks the last hold cycle, and a capture register shows the delivered word.

Top module: `xtalk_vc_tx`

## Requirements
- R1: After reset, `in_ready` is 1, `rx_strobe` is 0, and both `bus_out` and `rx_data` are all zeros. The all-zero word is the reference for the first comparison.
- R2: Each line's change is graded against the word on `bus_out` as rising, falling or steady. A bit position beyond either end of the bus counts as a steady neighbour. Each line gets a coupling factor, which is the sum of the costs of its two neighbours. If the line switches, a steady neighbour costs 1, a neighbour switching the same way costs 0, and a neighbour switching the opposite way costs 2. If the line is steady, a switching neighbour costs 1 and a steady one costs 0. The class of the word is the largest factor over all lines, from 0 to 4.
- R3: A word of class 0 or 1 is held for HOLD_LOW fast cycles (default 1). Examples are repeating the word on the bus, or every line moving the same way.
- R4: A word of class 2 is held for HOLD_MID fast cycles (default 2). An example is a single isolated line switching, including a line at either end of the bus.
- R5: A word of class 3 or 4 is held for HOLD_HIGH fast cycles (default 3). Class 4 is a line switching opposite to both of its neighbours.
- R6: A word is accepted on a clock edge where `in_valid` and `in_ready` are both 1. It appears on `bus_out` after that edge and stays unchanged until the next accepted word.
- R7: `in_ready` is 0 in every hold cycle except the last one. It is 1 in the last hold cycle and whenever the block is idle.
- R8: `rx_strobe` is 1 for exactly the last hold cycle of each word. On the edge that ends that cycle, `rx_data` takes the word on `bus_out`.
- R9: With `in_valid` held high, words follow one another with no gap. Strobes are spaced by the hold of each word, and `rx_data` delivers the stream in order and unaltered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Sender offers a word |
| in_data | input | WIDTH | Word offered by the sender |
| in_ready | output | 1 | Block can accept a word on this edge |
| bus_out | output | WIDTH | Value driven on the bus wires |
| rx_strobe | output | 1 | Receive strobe, high in the last hold cycle |
| rx_data | output | WIDTH | Word captured at the receive strobe |

## Verification
The hardest situation to reach is a specific coupling class. The class depends on the pair formed by the word already on the wires and the new word, not on the new word alone. The directed scenarios therefore build each pair as a chain: every word is chosen to be both the target of one class and the reference for the next, reaching class 4, isolated switching at the top edge, and uniform movement.

Back-to-back streams are the other hard case. There the last hold cycle of one word overlaps the acceptance of the next. The random stream keeps `in_valid` high throughout and checks every strobe spacing against a class computed independently from signed line deltas.

// File: rtl/xtalk_vc_tx.sv
module xtalk_vc_tx #(
  parameter int WIDTH     = 16,
  parameter int HOLD_LOW  = 1,
  parameter int HOLD_MID  = 2,
  parameter int HOLD_HIGH = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [WIDTH-1:0] in_data,
  output logic             in_ready,
  output logic [WIDTH-1:0] bus_out,
  output logic             rx_strobe,
  output logic [WIDTH-1:0] rx_data
);
  localparam int HMAX12 = (HOLD_LOW > HOLD_MID) ? HOLD_LOW : HOLD_MID;
  localparam int HMAX   = (HMAX12 > HOLD_HIGH) ? HMAX12 : HOLD_HIGH;
  localparam int CW     = $clog2(HMAX + 1);

  logic [WIDTH-1:0] line_q;
  logic [CW-1:0]    hold_q;
  logic [CW-1:0]    hold_sel;
  logic [WIDTH+1:0] rise_x, fall_x;
  logic [WIDTH-1:0] sev_hi, sev_mid;

  assign rise_x = {1'b0, in_data & ~line_q, 1'b0};
  assign fall_x = {1'b0, ~in_data & line_q, 1'b0};

  function automatic logic [2:0] pair_cost(input logic cu, input logic cd,
                                           input logic nu, input logic nd);
    if (!(cu | cd))      return {2'b00, nu | nd};
    else if (!(nu | nd)) return 3'd1;
    else if (cu == nu)   return 3'd0;
    else                 return 3'd2;
  endfunction

  for (genvar i = 0; i < WIDTH; i++) begin : g_line
    logic [2:0] factor;
    assign factor = pair_cost(rise_x[i+1], fall_x[i+1], rise_x[i],   fall_x[i])
                  + pair_cost(rise_x[i+1], fall_x[i+1], rise_x[i+2], fall_x[i+2]);
    assign sev_hi[i]  = (factor >= 3'd3);
    assign sev_mid[i] = (factor == 3'd2);
  end

  always_comb begin
    if (|sev_hi)       hold_sel = CW'(HOLD_HIGH);
    else if (|sev_mid) hold_sel = CW'(HOLD_MID);
    else               hold_sel = CW'(HOLD_LOW);
  end

  assign in_ready  = (hold_q <= CW'(1));
  assign rx_strobe = (hold_q == CW'(1));
  assign bus_out   = line_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_q  <= '0;
      hold_q  <= '0;
      rx_data <= '0;
    end else begin
      if (in_valid && in_ready) begin
        line_q <= in_data;
        hold_q <= hold_sel;
      end else if (hold_q != '0) begin
        hold_q <= hold_q - CW'(1);
      end
      if (rx_strobe) rx_data <= line_q;
    end
  end
endmodule

// File: rtl/xtalk_vc_tx_chk.sv
module xtalk_vc_tx_chk #(
  parameter int WIDTH    = 16,
  parameter int HOLD_LOW = 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic [WIDTH-1:0] in_data,
  input logic             in_ready,
  input logic [WIDTH-1:0] bus_out,
  input logic             rx_strobe,
  input logic [WIDTH-1:0] rx_data
);
  a_r6_word_follows_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> (bus_out == $past(in_data)));

  a_r6_bus_held_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
    !in_ready |=> $stable(bus_out));

  a_r7_strobe_only_when_ready: assert property (@(posedge clk) disable iff (!rst_n)
    rx_strobe |-> in_ready);

  a_r8_capture_on_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    rx_strobe |=> (rx_data == $past(bus_out)));

  a_r8_rx_stable_otherwise: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_strobe |=> $stable(rx_data));

  a_r3_repeat_word_fast: assert property (@(posedge clk) disable iff (!rst_n)
    (HOLD_LOW == 1 && in_valid && in_ready && in_data == bus_out) |=> rx_strobe);
endmodule

bind xtalk_vc_tx xtalk_vc_tx_chk #(.WIDTH(WIDTH), .HOLD_LOW(HOLD_LOW)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
  .in_ready(in_ready), .bus_out(bus_out), .rx_strobe(rx_strobe), .rx_data(rx_data));

// File: tb/test_xtalk_vc_tx.sv
`timescale 1ns/1ps
module test_xtalk_vc_tx;
  localparam int W = 16;
  localparam int HL = 1, HM = 2, HH = 3;

  logic clk = 0, rst_n = 0, in_valid = 0;
  logic [W-1:0] in_data = '0;
  logic in_ready, rx_strobe;
  logic [W-1:0] bus_out, rx_data;
  int vectors = 0, errors = 0;
  logic [W-1:0] last_sent = '0;
  bit done = 0;

  always #10 clk = ~clk;

  xtalk_vc_tx #(.WIDTH(W), .HOLD_LOW(HL), .HOLD_MID(HM), .HOLD_HIGH(HH)) i_xtalk_vc_tx (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .in_ready(in_ready), .bus_out(bus_out), .rx_strobe(rx_strobe), .rx_data(rx_data));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    vectors++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic int expected_hold(input logic [W-1:0] prev, input logic [W-1:0] nxt);
    int d[W+2];
    int worst = 0;
    for (int i = 0; i < W + 2; i++) d[i] = 0;
    for (int i = 0; i < W; i++) d[i+1] = int'(nxt[i]) - int'(prev[i]);
    for (int i = 1; i <= W; i++) begin
      int a = d[i] - d[i-1];
      int b = d[i] - d[i+1];
      int f = (a < 0 ? -a : a) + (b < 0 ? -b : b);
      if (f > worst) worst = f;
    end
    return (worst <= 1) ? HL : (worst == 2) ? HM : HH;
  endfunction

  task automatic send_one(input logic [W-1:0] w, input int exp_hold, input string req);
    int k;
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    in_valid = 1; in_data = w;
    @(negedge clk);
    in_valid = 0;
    check(bus_out == w, "R6", bus_out, w);
    k = 1;
    while (!rx_strobe && k < 20) begin
      check(!in_ready, "R7", in_ready, 0);
      @(negedge clk); k++;
    end
    check(k == exp_hold, req, k, exp_hold);
    check(rx_strobe && in_ready, "R8", {rx_strobe, in_ready}, 3);
    @(negedge clk);
    check(rx_data == w && !rx_strobe, "R8", rx_data, w);
    last_sent = w;
  endtask

  task automatic test_reset();
    check(in_ready == 1 && rx_strobe == 0, "R1", {in_ready, rx_strobe}, 2);
    check(bus_out == 0 && rx_data == 0, "R1", bus_out | rx_data, 0);
  endtask

  task automatic test_classes();
    send_one(16'h0000, HL, "R3 repeat of reset word");
    send_one(16'hFFFF, HL, "R3 all rising");
    send_one(16'h0000, HL, "R3 all falling");
    send_one(16'h0001, HM, "R4 isolated low edge line");
    send_one(16'h0002, HH, "R5 class 3 opposite pair at edge");
    send_one(16'h0005, HH, "R5 class 4 centre against both");
    send_one(16'h0000, HM, "R2 reference is bus word, two isolated falls");
    send_one(16'h8000, HM, "R4 isolated top edge line");
    send_one(16'h0000, HM, "R4 top edge fall");
    send_one(16'hC000, HL, "R2 top pair rising with steady edge");
    send_one(16'h4000, HM, "R4 top line falls beside steady");
  endtask

  task automatic test_stream(input int n);
    logic [W-1:0] prev = last_sent;
    logic [W-1:0] held = last_sent;
    bit first = 1;
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    for (int i = 0; i < n; i++) begin
      logic [W-1:0] w = W'($urandom);
      int h;
      if (i % 5 == 0) w = prev;
      if (i % 7 == 3) w = prev ^ (W'(1) << (i % W));
      h = expected_hold(prev, w);
      check(in_ready == 1, "R9 no gap", in_ready, 1);
      in_valid = 1; in_data = w;
      for (int k = 1; k <= h; k++) begin
        @(negedge clk);
        if (k == 1) begin
          check(bus_out == w, "R6", bus_out, w);
          if (!first) check(rx_data == held, "R9 data order", rx_data, held);
        end
        check(rx_strobe == (k == h), "R9 strobe spacing", rx_strobe, k == h);
      end
      first = 0; held = w; prev = w;
    end
    in_valid = 0;
    @(negedge clk);
    check(rx_data == held, "R9 last word", rx_data, held);
    last_sent = prev;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    test_reset();
    rst_n = 1;
    test_classes();
    test_stream(400);
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      vectors++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end
endmodule